// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block handles every stack transfer of an 8-bit processor with a 16-bit address bus. It also handles the vector fetches that start execution after reset and after a software break. The instruction decoder asks for one operation at a time through a one-hot request input. The block then runs a short fixed sequence of byte accesses on a simple memory port. While it runs, it keeps its own 8-bit stack pointer. When the sequence ends, it reports the new program counter, status byte or accumulator value, each with its own update strobe.

The stack sits in the fixed page 0x01. A push writes to the current pointer and then decrements it. A pull first increments the pointer and then reads. The block also applies the processor's irregular rules:

- A subroutine call saves its return address minus one, and a return adds one back.
- A software break skips one padding byte after its opcode.
- Every status byte written to the stack has the break bit and the unused bit set.
- Status bytes loaded back from the stack have the same two bits forced.

Operands (`pc_i`, `target_i`, `status_i`, `acc_i`) are captured in the same cycle that a request is accepted. When the hardware reset is released, the block starts its own boot sequence without any request.

Top module: `stk_engine`

## Requirements
- R1: After `rst_n` is released, and also on request bit 0, the block runs an 8-cycle boot sequence. It idles for 5 cycles, reads 0xFFFC and then 0xFFFD, and spends one final cycle with no bus access. The stack pointer is set to 0xFD. `pc_o` takes the value {byte at 0xFFFD, byte at 0xFFFC}, and `status_o` becomes 0x34 (interrupt-disable bit 2, break bit 4 and bit 5 all set).
- R2: A push writes to address 0x0100+SP and then decrements SP. A pull increments SP and then reads from 0x0100+SP. SP wraps modulo 256 in both directions, and every stack access stays in page 0x01.
- R3: A break (request bit 1) forms P = `pc_i`+1 and pushes P high, P low, and then `status_i`|0x30. It then reads 0xFFFE and 0xFFFF. `pc_o` becomes {byte at 0xFFFF, byte at 0xFFFE} and `status_o` becomes `status_i`|0x34. The pushed status keeps the interrupt-disable bit that was present before the break.
- R4: A call (request bit 2) pushes (`pc_i`−1) mod 65536, high byte first, and loads `pc_o` with `target_i`.
- R5: A return (request bit 3) pulls the low byte and then the high byte. `pc_o` becomes their concatenation plus 1, taken modulo 65536.
- R6: A return from interrupt (request bit 4) pulls the status byte, then the PC low byte, then the PC high byte. `status_o` becomes the pulled byte|0x30 and `pc_o` is loaded with no adjustment.
- R7: Request bit 5 pushes `acc_i`. Request bit 6 pushes `status_i`|0x30. Neither request raises `status_we_o` or `pc_we_o`.
- R8: Request bit 7 pulls one byte into `acc_o`. Request bit 8 pulls one byte, and `status_o` becomes that byte|0x30.
- R9: `busy_o` is high from the cycle after a request is accepted until the last cycle of its sequence. In the cycle after that, `done_o` pulses for one cycle together with the update strobes that apply. A request that arrives while busy is ignored. A request with more than one bit set is ignored.
- R10: Read data arrives one cycle after a read request. A read and a write never happen in the same cycle. The number of busy cycles for each request is: boot 8, break 6, call 2, return 3, return from interrupt 4, each push 1, each pull 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 9 | One-hot operation request (bit order given in R1 to R8) |
| pc_i | input | 16 | Current program counter operand |
| target_i | input | 16 | Call destination |
| status_i | input | 8 | Live status byte |
| acc_i | input | 8 | Accumulator value to push |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read request |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 8 | Stack pointer |
| pc_o | output | 16 | New program counter |
| pc_we_o | output | 1 | `pc_o` is valid with `done_o` |
| status_o | output | 8 | New status byte |
| status_we_o | output | 1 | `status_o` is valid with `done_o` |
| acc_o | output | 8 | Pulled accumulator byte |
| acc_we_o | output | 1 | `acc_o` is valid with `done_o` |

## Verification
The assertions assume three things about the memory and the requester. The memory returns data exactly one cycle after a read request. The requester holds a request for only one cycle. Operands are valid in the cycle the request is accepted. The stimulus meets these assumptions: it drives requests at the falling edge for a single cycle, and a bench memory answers reads with one register of delay. Requests that break the one-hot or idle-only assumptions are driven on purpose, both during a break sequence and while the block is idle, and the bench checks that the bus and the pointer ignore them.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 2 * DW;
  localparam int unsigned NUM_CMD = 9;

  // Request bit order matches the enum order.
  typedef enum logic [3:0] {
    C_RST, C_BRK, C_JSR, C_RTS, C_RTI, C_PHA, C_PHP, C_PLA, C_PLP
  } cmd_e;

  typedef enum logic [1:0] {K_IDLE, K_PUSH, K_PULL, K_VEC} kind_e;
  typedef enum logic [1:0] {W_PCH, W_PCL, W_ST, W_ACC}     wsel_e;
  typedef enum logic [1:0] {D_NONE, D_LO, D_HI, D_ST}      dest_e;

  typedef struct packed {
    kind_e kind;
    wsel_e wsel;
    dest_e dest;
    logic  last;
  } step_t;

  localparam logic [DW-1:0] ST_PUSH_SET = 8'h30;
  localparam logic [DW-1:0] ST_IRQ_SET  = 8'h34;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter logic [DW-1:0] PAGE     = 8'h01,
  parameter logic [DW-1:0] RESET_SP = 8'hFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          push_i,
  input  logic          pull_i,
  output logic [DW-1:0] sp_o,
  output logic [AW-1:0] addr_o
);
  logic [DW-1:0] sp_q, sp_d, sp_inc;
  logic          sp_en;

  assign sp_inc = sp_q + 8'd1;
  assign addr_o = {PAGE, pull_i ? sp_inc : sp_q};
  assign sp_o   = sp_q;

  always_comb begin
    sp_en = init_i | push_i | pull_i;
    sp_d  = sp_q;
    if (init_i)      sp_d = RESET_SP;
    else if (push_i) sp_d = sp_q - 8'd1;
    else if (pull_i) sp_d = sp_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RESET_SP;
    else if (sp_en) sp_q <= sp_d;
  end

  p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pull_i));
endmodule

// File: rtl/stk_ctl.sv
module stk_ctl
  import stk_pkg::*;
#(
  parameter int unsigned BOOT_WAIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMD-1:0] req_i,
  output logic               busy_o,
  output logic               accept_o,
  output logic               init_sp_o,
  output cmd_e               cmd_o,
  output step_t              step_o,
  output logic               finish_o
);
  localparam int unsigned CNT_W = $clog2(BOOT_WAIT + 4);
  localparam logic [CNT_W-1:0] I0  = CNT_W'(0);
  localparam logic [CNT_W-1:0] I1  = CNT_W'(1);
  localparam logic [CNT_W-1:0] I2  = CNT_W'(2);
  localparam logic [CNT_W-1:0] I3  = CNT_W'(3);
  localparam logic [CNT_W-1:0] I4  = CNT_W'(4);
  localparam logic [CNT_W-1:0] BW0 = CNT_W'(BOOT_WAIT);
  localparam logic [CNT_W-1:0] BW1 = CNT_W'(BOOT_WAIT + 1);

  logic             run_q, run_d, boot_q, boot_d;
  cmd_e             cmd_q, cmd_d, req_cmd, start_cmd;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             req_ok, start, ctl_en;
  step_t            cur;

  function automatic step_t mk(kind_e k, wsel_e w, dest_e d, logic l);
    step_t s;
    s.kind = k; s.wsel = w; s.dest = d; s.last = l;
    return s;
  endfunction

  function automatic step_t decode(cmd_e c, logic [CNT_W-1:0] i);
    step_t s;
    s = mk(K_IDLE, W_PCH, D_NONE, 1'b1);
    unique case (c)
      C_RST: begin
        if (i < BW0)       s = mk(K_IDLE, W_PCH, D_NONE, 1'b0);
        else if (i == BW0) s = mk(K_VEC,  W_PCH, D_LO,   1'b0);
        else if (i == BW1) s = mk(K_VEC,  W_PCH, D_HI,   1'b0);
      end
      C_BRK: begin
        if (i == I0)      s = mk(K_PUSH, W_PCH, D_NONE, 1'b0);
        else if (i == I1) s = mk(K_PUSH, W_PCL, D_NONE, 1'b0);
        else if (i == I2) s = mk(K_PUSH, W_ST,  D_NONE, 1'b0);
        else if (i == I3) s = mk(K_VEC,  W_PCH, D_LO,   1'b0);
        else if (i == I4) s = mk(K_VEC,  W_PCH, D_HI,   1'b0);
      end
      C_JSR: begin
        if (i == I0) s = mk(K_PUSH, W_PCH, D_NONE, 1'b0);
        else         s = mk(K_PUSH, W_PCL, D_NONE, 1'b1);
      end
      C_RTS: begin
        if (i == I0)      s = mk(K_PULL, W_PCH, D_LO, 1'b0);
        else if (i == I1) s = mk(K_PULL, W_PCH, D_HI, 1'b0);
      end
      C_RTI: begin
        if (i == I0)      s = mk(K_PULL, W_PCH, D_ST, 1'b0);
        else if (i == I1) s = mk(K_PULL, W_PCH, D_LO, 1'b0);
        else if (i == I2) s = mk(K_PULL, W_PCH, D_HI, 1'b0);
      end
      C_PHA: s = mk(K_PUSH, W_ACC, D_NONE, 1'b1);
      C_PHP: s = mk(K_PUSH, W_ST,  D_NONE, 1'b1);
      C_PLA: if (i == I0) s = mk(K_PULL, W_PCH, D_LO, 1'b0);
      C_PLP: if (i == I0) s = mk(K_PULL, W_PCH, D_ST, 1'b0);
      default: s = mk(K_IDLE, W_PCH, D_NONE, 1'b1);
    endcase
    return s;
  endfunction

  always_comb begin
    req_cmd = C_RST;
    for (int k = 0; k < int'(NUM_CMD); k++) begin
      if (req_i[k]) req_cmd = cmd_e'(4'(k));
    end
  end

  assign req_ok    = $onehot(req_i);
  assign start     = !run_q && (boot_q || req_ok);
  assign start_cmd = boot_q ? C_RST : req_cmd;
  assign cur       = run_q ? decode(cmd_q, idx_q) : mk(K_IDLE, W_PCH, D_NONE, 1'b0);

  always_comb begin
    ctl_en = start || run_q;
    run_d  = run_q;
    cmd_d  = cmd_q;
    idx_d  = idx_q;
    boot_d = boot_q;
    if (start) begin
      run_d  = 1'b1;
      cmd_d  = start_cmd;
      idx_d  = '0;
      boot_d = 1'b0;
    end else if (run_q) begin
      if (cur.last) run_d = 1'b0;
      else          idx_d = idx_q + I1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      boot_q <= 1'b1;
      cmd_q  <= C_RST;
      idx_q  <= '0;
    end else if (ctl_en) begin
      run_q  <= run_d;
      boot_q <= boot_d;
      cmd_q  <= cmd_d;
      idx_q  <= idx_d;
    end
  end

  assign busy_o    = run_q;
  assign accept_o  = start;
  assign init_sp_o = start && (start_cmd == C_RST);
  assign cmd_o     = cmd_q;
  assign step_o    = cur;
  assign finish_o  = run_q && cur.last;

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cur.last) |=> (run_q && cmd_q == $past(cmd_q)));
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !accept_o);
endmodule

// File: rtl/stk_collect.sv
module stk_collect
  import stk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd_i,
  input  step_t         step_i,
  input  logic          finish_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] op_st_i,
  input  logic [AW-1:0] op_tgt_i,
  output logic [AW-1:0] pc_o,
  output logic          pc_we_o,
  output logic [DW-1:0] st_o,
  output logic          st_we_o,
  output logic [DW-1:0] acc_o,
  output logic          acc_we_o,
  output logic          done_o
);
  dest_e         pend_q, pend_d;
  logic [DW-1:0] lo_q, hi_q, sb_q;
  logic [DW-1:0] eff_lo, eff_hi, eff_st;
  logic [AW-1:0] pc_q, pc_n, pulled_pc;
  logic [DW-1:0] st_q, st_n, acc_q, acc_n;
  logic          pcw_n, stw_n, accw_n;
  logic          pcw_q, stw_q, accw_q, done_q;

  assign pend_d    = (step_i.kind == K_PULL || step_i.kind == K_VEC) ? step_i.dest : D_NONE;
  assign eff_lo    = (pend_q == D_LO) ? rdata_i : lo_q;
  assign eff_hi    = (pend_q == D_HI) ? rdata_i : hi_q;
  assign eff_st    = (pend_q == D_ST) ? rdata_i : sb_q;
  assign pulled_pc = {eff_hi, eff_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= D_NONE;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      sb_q <= '0;
    end else begin
      if (pend_q == D_LO) lo_q <= rdata_i;
      if (pend_q == D_HI) hi_q <= rdata_i;
      if (pend_q == D_ST) sb_q <= rdata_i;
    end
  end

  always_comb begin
    pc_n   = pc_q;
    st_n   = st_q;
    acc_n  = acc_q;
    pcw_n  = 1'b0;
    stw_n  = 1'b0;
    accw_n = 1'b0;
    if (finish_i) begin
      unique case (cmd_i)
        C_RST: begin pc_n = pulled_pc; st_n = ST_IRQ_SET; pcw_n = 1'b1; stw_n = 1'b1; end
        C_BRK: begin pc_n = pulled_pc; st_n = op_st_i | ST_IRQ_SET; pcw_n = 1'b1; stw_n = 1'b1; end
        C_JSR: begin pc_n = op_tgt_i; pcw_n = 1'b1; end
        C_RTS: begin pc_n = pulled_pc + 16'd1; pcw_n = 1'b1; end
        C_RTI: begin pc_n = pulled_pc; st_n = eff_st | ST_PUSH_SET; pcw_n = 1'b1; stw_n = 1'b1; end
        C_PLA: begin acc_n = eff_lo; accw_n = 1'b1; end
        C_PLP: begin st_n = eff_st | ST_PUSH_SET; stw_n = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      st_q  <= ST_IRQ_SET;
      acc_q <= '0;
    end else if (finish_i) begin
      pc_q  <= pc_n;
      st_q  <= st_n;
      acc_q <= acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcw_q  <= 1'b0;
      stw_q  <= 1'b0;
      accw_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pcw_q  <= pcw_n;
      stw_q  <= stw_n;
      accw_q <= accw_n;
      done_q <= finish_i;
    end
  end

  assign pc_o     = pc_q;
  assign pc_we_o  = pcw_q;
  assign st_o     = st_q;
  assign st_we_o  = stw_q;
  assign acc_o    = acc_q;
  assign acc_we_o = accw_q;
  assign done_o   = done_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_strobe_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_o || st_we_o || acc_we_o) |-> done_o);
  p_status_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_we_o |-> (st_o[5:4] == 2'b11));
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [DW-1:0] RESET_SP   = 8'hFD,
  parameter logic [AW-1:0] BOOT_VEC   = 16'hFFFC,
  parameter logic [AW-1:0] BRK_VEC    = 16'hFFFE,
  parameter int unsigned   BOOT_WAIT  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMD-1:0] req_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [AW-1:0]      target_i,
  input  logic [DW-1:0]      status_i,
  input  logic [DW-1:0]      acc_i,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DW-1:0]      sp_o,
  output logic [AW-1:0]      pc_o,
  output logic               pc_we_o,
  output logic [DW-1:0]      status_o,
  output logic               status_we_o,
  output logic [DW-1:0]      acc_o,
  output logic               acc_we_o
);
  step_t         step;
  cmd_e          cmd;
  logic          accept, init_sp, finish;
  logic          is_push, is_pull;
  logic [AW-1:0] stk_addr, vec_addr, push_pc;
  logic [AW-1:0] pc_q, tgt_q;
  logic [DW-1:0] st_q, acc_q;

  stk_ctl #(.BOOT_WAIT(BOOT_WAIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o),
    .accept_o(accept), .init_sp_o(init_sp), .cmd_o(cmd),
    .step_o(step), .finish_o(finish)
  );

  assign is_push = (step.kind == K_PUSH);
  assign is_pull = (step.kind == K_PULL);

  stk_ptr #(.PAGE(STACK_PAGE), .RESET_SP(RESET_SP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .init_i(init_sp), .push_i(is_push),
    .pull_i(is_pull), .sp_o(sp_o), .addr_o(stk_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      tgt_q <= '0;
      st_q  <= '0;
      acc_q <= '0;
    end else if (accept) begin
      pc_q  <= pc_i;
      tgt_q <= target_i;
      st_q  <= status_i;
      acc_q <= acc_i;
    end
  end

  // break skips a padding byte; a call saves its last operand address
  assign push_pc  = (cmd == C_BRK) ? pc_q + 16'd1 : pc_q - 16'd1;
  assign vec_addr = ((cmd == C_RST) ? BOOT_VEC : BRK_VEC) + AW'(step.dest == D_HI);

  always_comb begin
    mem_we_o    = is_push;
    mem_re_o    = is_pull || (step.kind == K_VEC);
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (is_push || is_pull)       mem_addr_o = stk_addr;
    else if (step.kind == K_VEC)  mem_addr_o = vec_addr;
    if (is_push) begin
      unique case (step.wsel)
        W_PCH:   mem_wdata_o = push_pc[AW-1:DW];
        W_PCL:   mem_wdata_o = push_pc[DW-1:0];
        W_ST:    mem_wdata_o = st_q | ST_PUSH_SET;
        default: mem_wdata_o = acc_q;
      endcase
    end
  end

  stk_collect u_col (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .step_i(step), .finish_i(finish),
    .rdata_i(mem_rdata_i), .op_st_i(st_q), .op_tgt_i(tgt_q),
    .pc_o(pc_o), .pc_we_o(pc_we_o), .st_o(status_o), .st_we_o(status_we_o),
    .acc_o(acc_o), .acc_we_o(acc_we_o), .done_o(done_o)
  );

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (sp_o == 8'($past(sp_o) - 8'd1)));
  p_stack_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || is_pull) |-> (mem_addr_o[AW-1:DW] == STACK_PAGE));
  p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o));
  p_st_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && step.wsel == W_ST) |-> (mem_wdata_o[5:4] == 2'b11));
endmodule

// File: tb/test_stk_engine.sv
module test_stk_engine;
  localparam int B_RST = 0, B_BRK = 1, B_JSR = 2, B_RTS = 3, B_RTI = 4;
  localparam int B_PHA = 5, B_PHP = 6, B_PLA = 7, B_PLP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  req_i;
  logic [15:0] pc_i, target_i;
  logic [7:0]  status_i, acc_i;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        mem_we_o, mem_re_o;
  logic        busy_o, done_o, pc_we_o, status_we_o, acc_we_o;
  logic [7:0]  sp_o, status_o, acc_o;
  logic [15:0] pc_o;

  always #10 clk = ~clk;

  stk_engine i_stk_engine (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .pc_i(pc_i), .target_i(target_i),
    .status_i(status_i), .acc_i(acc_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o),
    .pc_o(pc_o), .pc_we_o(pc_we_o), .status_o(status_o),
    .status_we_o(status_we_o), .acc_o(acc_o), .acc_we_o(acc_we_o)
  );

  // bench memory, one cycle read latency
  logic [7:0] bmem [int];
  always @(posedge clk) begin
    if (mem_we_o) bmem[int'(mem_addr_o)] = mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= bmem.exists(int'(mem_addr_o)) ? bmem[int'(mem_addr_o)] : 8'h00;
  end

  // reference model
  typedef struct { bit we; bit re; int addr; int data; } op_t;
  op_t q[$];
  int  msp;
  int  mstk[256];
  int  e_pc, e_st, e_acc;
  bit  e_pcw, e_stw, e_accw;
  int  nchk = 0, nfail = 0;

  task automatic check(bit ok, string r, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic void m_idle();
    op_t o; o.we = 0; o.re = 0; o.addr = 0; o.data = 0; q.push_back(o);
  endfunction
  function automatic void m_push(int d);
    op_t o; o.we = 1; o.re = 0; o.addr = 256 + msp; o.data = d & 255;
    mstk[msp] = d & 255; msp = (msp - 1) & 255; q.push_back(o);
  endfunction
  function automatic int m_pull();
    op_t o;
    msp = (msp + 1) & 255;
    o.we = 0; o.re = 1; o.addr = 256 + msp; o.data = 0; q.push_back(o);
    return mstk[msp];
  endfunction
  function automatic void m_vec(int a);
    op_t o; o.we = 0; o.re = 1; o.addr = a; o.data = 0; q.push_back(o);
  endfunction

  function automatic void build(int c, int pcv, int tgt, int stv, int accv);
    int p, lo, hi, s;
    q.delete();
    e_pcw = 0; e_stw = 0; e_accw = 0;
    case (c)
      B_RST: begin
        msp = 'hFD;
        for (int k = 0; k < 5; k++) m_idle();
        m_vec('hFFFC); m_vec('hFFFD); m_idle();
        e_pc = 'h1234; e_st = 'h34; e_pcw = 1; e_stw = 1;
      end
      B_BRK: begin
        p = (pcv + 1) & 'hFFFF;
        m_push(p >> 8); m_push(p & 255); m_push(stv | 'h30);
        m_vec('hFFFE); m_vec('hFFFF); m_idle();
        e_pc = 'hABCD; e_st = stv | 'h34; e_pcw = 1; e_stw = 1;
      end
      B_JSR: begin
        p = (pcv - 1) & 'hFFFF;
        m_push(p >> 8); m_push(p & 255);
        e_pc = tgt; e_pcw = 1;
      end
      B_RTS: begin
        lo = m_pull(); hi = m_pull(); m_idle();
        e_pc = ((hi << 8 | lo) + 1) & 'hFFFF; e_pcw = 1;
      end
      B_RTI: begin
        s = m_pull(); lo = m_pull(); hi = m_pull(); m_idle();
        e_st = s | 'h30; e_pc = hi << 8 | lo; e_pcw = 1; e_stw = 1;
      end
      B_PHA: m_push(accv);
      B_PHP: m_push(stv | 'h30);
      B_PLA: begin e_acc = m_pull(); m_idle(); e_accw = 1; end
      default: begin s = m_pull(); m_idle(); e_st = s | 'h30; e_stw = 1; end
    endcase
  endfunction

  function automatic string tag_of(int c);
    case (c)
      B_RST: return "R1";
      B_BRK: return "R3";
      B_JSR: return "R4";
      B_RTS: return "R5";
      B_RTI: return "R6";
      B_PHA, B_PHP: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run(int c, int pcv, int tgt, int stv, int accv, bit drive, int poke_at);
    string t;
    t = tag_of(c);
    build(c, pcv, tgt, stv, accv);
    if (drive) begin
      pc_i = 16'(pcv); target_i = 16'(tgt); status_i = 8'(stv); acc_i = 8'(accv);
      req_i = 9'(1) << c;
    end
    @(posedge clk);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      req_i = '0;
      if (i == poke_at) req_i = 9'(1) << B_PHA;
      check(busy_o == 1'b1, "R10", "busy during step", int'(busy_o), 1);
      check(mem_we_o == q[i].we && mem_re_o == q[i].re, t, "bus op kind",
            {mem_we_o, mem_re_o}, {q[i].we, q[i].re});
      if (q[i].we || q[i].re)
        check(int'(mem_addr_o) == q[i].addr, t, "address", int'(mem_addr_o), q[i].addr);
      if (q[i].we)
        check(int'(mem_wdata_o) == q[i].data, t, "write data", int'(mem_wdata_o), q[i].data);
    end
    @(negedge clk);
    req_i = '0;
    check(done_o && !busy_o, "R9", "done pulse", {done_o, busy_o}, 2);
    check(pc_we_o == e_pcw && status_we_o == e_stw && acc_we_o == e_accw, t, "strobes",
          {pc_we_o, status_we_o, acc_we_o}, {e_pcw, e_stw, e_accw});
    if (e_pcw)  check(int'(pc_o) == e_pc, t, "pc", int'(pc_o), e_pc);
    if (e_stw)  check(int'(status_o) == e_st, t, "status", int'(status_o), e_st);
    if (e_accw) check(int'(acc_o) == e_acc, t, "acc", int'(acc_o), e_acc);
    check(int'(sp_o) == msp, "R2", "stack pointer", int'(sp_o), msp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_i = '0; pc_i = '0; target_i = '0; status_i = '0; acc_i = '0;
    for (int i = 0; i < 256; i++) begin
      mstk[i] = i ^ 'h5A;
      bmem[256 + i] = 8'(i ^ 'h5A);
    end
    bmem['hFFFC] = 8'h34; bmem['hFFFD] = 8'h12;
    bmem['hFFFE] = 8'hCD; bmem['hFFFF] = 8'hAB;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R1", "reset state quiet",
          {busy_o, done_o, mem_we_o, mem_re_o}, 0);
    check(sp_o == 8'hFD, "R1", "reset stack pointer", int'(sp_o), 'hFD);
    rst_n = 1'b1;
    run(B_RST, 0, 0, 0, 0, 1'b0, -1);          // R1 boot after release
    run(B_PLA, 0, 0, 0, 0, 1'b1, -1);          // R8 pulls from 0x1FE
    run(B_PLA, 0, 0, 0, 0, 1'b1, -1);          // R8 pulls from 0x1FF
    run(B_PLA, 0, 0, 0, 0, 1'b1, -1);          // R2 wraps up to 0x100
    run(B_PHA, 0, 0, 0, 'h77, 1'b1, -1);       // R2 wraps down after 0x100
    run(B_PHP, 0, 0, 'h81, 0, 1'b1, -1);       // R7 status push sets bits 4 and 5
    run(B_PLP, 0, 0, 0, 0, 1'b1, -1);          // R8
    run(B_JSR, 'hC003, 'hFFD2, 0, 0, 1'b1, -1); // R4
    run(B_RTS, 0, 0, 0, 0, 1'b1, -1);          // R5
    run(B_BRK, 'hC001, 0, 'h00, 0, 1'b1, -1);  // R3 with interrupt-disable clear
    run(B_RTI, 0, 0, 0, 0, 1'b1, -1);          // R6
    run(B_JSR, 'h0000, 'h4000, 0, 0, 1'b1, -1); // R4 return address wraps to 0xFFFF
    run(B_RTS, 0, 0, 0, 0, 1'b1, -1);          // R5 +1 wraps to 0x0000
    run(B_BRK, 'h2010, 0, 'h04, 0, 1'b1, 2);   // R9 request during busy ignored; R3 keeps I
    run(B_RTI, 0, 0, 0, 0, 1'b1, -1);          // R6
    // R9 request with two bits set is ignored
    @(negedge clk);
    req_i = 9'b0_1000_0100;
    @(posedge clk);
    @(negedge clk);
    req_i = '0;
    check(!busy_o && !mem_we_o && !mem_re_o, "R9", "multi-bit request ignored",
          {busy_o, mem_we_o, mem_re_o}, 0);
    check(int'(sp_o) == msp, "R9", "pointer after ignored request", int'(sp_o), msp);
    run(B_PHA, 0, 0, 0, 'hE5, 1'b1, -1);       // R7
    run(B_PLA, 0, 0, 0, 0, 1'b1, -1);          // R8 reads back 0xE5
    run(B_RST, 0, 0, 0, 0, 1'b1, -1);          // R1 boot through request bit 0
    finish_run();
  end
endmodule